// File: doc/BRIEF.md
# I2C Transmit/Receive Queue Level Unit

This block holds the two data queues of an I2C controller: a transmit queue of 10-bit words (an 8-bit data byte plus two control flag bits that the serial engine interprets) and a receive queue of bytes. Each queue is 16 entries deep by default. The host side pushes transmit words and pops received bytes. The serial engine side pops transmit words and pushes received bytes. Each pop port shows the head entry without a separate read strobe.

The unit reports how full each queue is as a count minus one. An empty queue also reads 0, so software tells "empty" from "one entry" with the empty flags in the status byte. A zero-based receive watermark register sets the receive level at which a watermark condition rises. The unit also produces level conditions for an empty transmit queue and for a transmit queue that has drained to half its depth. All three conditions go to an interrupt controller. A transmit-reset control input empties the transmit queue and holds it empty for as long as it stays high.

Top module: `i2c_fifo_level_unit`

## Requirements
- R1: Each queue keeps up to DEPTH entries (default 16) in first-in first-out order. The transmit entries are 10 bits wide and the receive entries are 8 bits wide. While a queue is not empty, its read-data output shows the oldest entry.
- R2: The occupancy outputs `tx_occ` and `rx_occ` show the number of stored entries minus one. An empty queue shows 0.
- R3: A push into a full queue is ignored, and a pop from an empty queue is ignored. In both cases the contents and the occupancy are left unchanged.
- R4: The receive watermark register is 4 bits wide and reads 0 after reset. A cycle with `rx_depth_wr` high loads `rx_depth_wdata`, and the new value shows on `rx_depth_q` after that clock edge.
- R5: `rx_wm_irq` is high exactly when the receive count is at least the watermark value plus one.
- R6: While `tx_fifo_rst` is high, the transmit queue reads empty and ignores pushes and pops. It is still empty in the cycle after release.
- R7: `status` bit 4 is transmit full, bit 5 is receive full (count equals DEPTH), bit 6 is receive empty and bit 7 is transmit empty. Bits 3 to 0 read 0.
- R8: `tx_empty_irq` is high exactly when the transmit queue holds no entry. `tx_half_irq` is high exactly when the queue holds DEPTH/2 entries or fewer.
- R9: A push and a pop in the same cycle on a queue that is neither full nor empty both take effect, and the count stays the same. The push-is-full test uses the count from before that edge.
- R10: While reset is asserted, and once it is released, both queues are empty: `status` reads 8'hC0 and both occupancies read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_push | input | 1 | Host writes a transmit word |
| tx_wdata | input | 10 | Transmit word: data byte plus two flag bits |
| tx_pop | input | 1 | Serial engine takes the head transmit word |
| tx_rdata | output | 10 | Head of the transmit queue |
| rx_push | input | 1 | Serial engine stores a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host takes the head received byte |
| rx_rdata | output | 8 | Head of the receive queue |
| tx_fifo_rst | input | 1 | Control level: holds the transmit queue empty |
| rx_depth_wr | input | 1 | Load strobe for the receive watermark |
| rx_depth_wdata | input | 4 | New zero-based receive watermark |
| rx_depth_q | output | 4 | Current receive watermark |
| tx_occ | output | 4 | Transmit count minus one |
| rx_occ | output | 4 | Receive count minus one |
| status | output | 8 | Full/empty flags in bits 7..4 |
| rx_wm_irq | output | 1 | Receive watermark reached (level) |
| tx_empty_irq | output | 1 | Transmit queue empty (level) |
| tx_half_irq | output | 1 | Transmit queue at or below half (level) |

## Verification
The bench uses the default parameters: a depth of 16, 10-bit transmit words and 8-bit receive bytes. With these values a short run fills both queues past full, sweeps the watermark across its whole 0..15 range, and crosses the half-depth boundary at 8 entries in both directions. The smallest watermark value rises on the first byte. The largest coincides with the receive-full flag. Random mixed traffic with same-cycle pushes and pops on both queues exercises every count from 0 to 16.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  // status byte bit positions (decoded by the host side)
  localparam int ST_TX_FULL  = 4;
  localparam int ST_RX_FULL  = 5;
  localparam int ST_RX_EMPTY = 6;
  localparam int ST_TX_EMPTY = 7;
  localparam int ST_W        = 8;

  typedef struct packed {
    logic full;
    logic empty;
  } q_flags_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter  int WIDTH = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, wr_ptr_nx, rd_ptr, rd_ptr_nx;
  logic [CW-1:0]    cnt_nx;
  logic             push_ok, pop_ok;

  // accept decisions use the count held before this edge
  assign push_ok = push & ~flush & (count != FULLC);
  assign pop_ok  = pop  & ~flush & (count != '0);

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    cnt_nx    = count;
    if (flush) begin
      wr_ptr_nx = '0;
      rd_ptr_nx = '0;
      cnt_nx    = '0;
    end else begin
      if (push_ok) wr_ptr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr_nx = (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_nx = count + CW'(1);
        2'b01:   cnt_nx = count - CW'(1);
        default: cnt_nx = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= cnt_nx;
    end
  end

  // storage: written only on an accepted push, no reset
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/i2cq_level.sv
module i2cq_level
  import i2cq_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic [CW-1:0]   tx_count,
  input  logic [CW-1:0]   rx_count,
  input  logic [AW-1:0]   rx_depth,
  output logic [AW-1:0]   tx_occ,
  output logic [AW-1:0]   rx_occ,
  output logic [ST_W-1:0] status,
  output logic            wm_hit,
  output logic            tx_empty_lvl,
  output logic            tx_half_lvl
);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);

  logic [CW-1:0] cnts [2];
  logic [AW-1:0] occs [2];
  q_flags_t      flg  [2];

  assign cnts[0] = tx_count;
  assign cnts[1] = rx_count;

  // count-minus-one readback, clamped at zero for an empty queue
  for (genvar g = 0; g < 2; g++) begin : g_occ
    logic [CW-1:0] dec;
    assign dec         = cnts[g] - CW'(1);
    assign flg[g].empty = (cnts[g] == '0);
    assign flg[g].full  = (cnts[g] == FULLC);
    assign occs[g]      = flg[g].empty ? '0 : dec[AW-1:0];
  end

  assign tx_occ = occs[0];
  assign rx_occ = occs[1];

  always_comb begin
    status              = '0;
    status[ST_TX_FULL]  = flg[0].full;
    status[ST_RX_FULL]  = flg[1].full;
    status[ST_RX_EMPTY] = flg[1].empty;
    status[ST_TX_EMPTY] = flg[0].empty;
  end

  assign wm_hit       = (rx_count >= ({1'b0, rx_depth} + CW'(1)));
  assign tx_empty_lvl = flg[0].empty;
  assign tx_half_lvl  = (tx_count <= HALFC);
endmodule

// File: rtl/i2c_fifo_level_unit.sv
module i2c_fifo_level_unit
  import i2cq_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int TXW   = 10,
  parameter  int RXW   = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_push,
  input  logic [TXW-1:0]  tx_wdata,
  input  logic            tx_pop,
  output logic [TXW-1:0]  tx_rdata,
  input  logic            rx_push,
  input  logic [RXW-1:0]  rx_wdata,
  input  logic            rx_pop,
  output logic [RXW-1:0]  rx_rdata,
  input  logic            tx_fifo_rst,
  input  logic            rx_depth_wr,
  input  logic [AW-1:0]   rx_depth_wdata,
  output logic [AW-1:0]   rx_depth_q,
  output logic [AW-1:0]   tx_occ,
  output logic [AW-1:0]   rx_occ,
  output logic [ST_W-1:0] status,
  output logic            rx_wm_irq,
  output logic            tx_empty_irq,
  output logic            tx_half_irq
);
  logic [1:0]    rst_sync;
  logic          rst_core_n;
  logic [CW-1:0] tx_count, rx_count;
  logic [AW-1:0] depth_nx;

  // assert asynchronously, release after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  // receive watermark register
  always_comb begin
    depth_nx = rx_depth_q;
    if (rx_depth_wr) depth_nx = rx_depth_wdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rx_depth_q <= '0;
    else             rx_depth_q <= depth_nx;
  end

  i2cq_fifo #(.WIDTH(TXW), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_core_n),
    .flush (tx_fifo_rst),
    .push  (tx_push),
    .wdata (tx_wdata),
    .pop   (tx_pop),
    .rdata (tx_rdata),
    .count (tx_count)
  );

  i2cq_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_core_n),
    .flush (1'b0),
    .push  (rx_push),
    .wdata (rx_wdata),
    .pop   (rx_pop),
    .rdata (rx_rdata),
    .count (rx_count)
  );

  i2cq_level #(.DEPTH(DEPTH)) u_level (
    .tx_count     (tx_count),
    .rx_count     (rx_count),
    .rx_depth     (rx_depth_q),
    .tx_occ       (tx_occ),
    .rx_occ       (rx_occ),
    .status       (status),
    .wm_hit       (rx_wm_irq),
    .tx_empty_lvl (tx_empty_irq),
    .tx_half_lvl  (tx_half_irq)
  );
endmodule

// File: rtl/i2cq_checker.sv
module i2cq_checker
  import i2cq_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int TXW   = 10,
  parameter  int RXW   = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_push,
  input logic [TXW-1:0]  tx_wdata,
  input logic            tx_pop,
  input logic [TXW-1:0]  tx_rdata,
  input logic            rx_push,
  input logic [RXW-1:0]  rx_wdata,
  input logic            rx_pop,
  input logic [RXW-1:0]  rx_rdata,
  input logic            tx_fifo_rst,
  input logic            rx_depth_wr,
  input logic [AW-1:0]   rx_depth_wdata,
  input logic [AW-1:0]   rx_depth_q,
  input logic [AW-1:0]   tx_occ,
  input logic [AW-1:0]   rx_occ,
  input logic [ST_W-1:0] status,
  input logic            rx_wm_irq,
  input logic            tx_empty_irq,
  input logic            tx_half_irq
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_TX_FULL] && tx_push && !tx_pop && !tx_fifo_rst
      |=> status[ST_TX_FULL] && $stable(tx_occ));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_RX_EMPTY] && rx_pop && !rx_push |=> status[ST_RX_EMPTY]);

  assert_txrst_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_rst |=> status[ST_TX_EMPTY] && tx_empty_irq && (tx_occ == '0));

  assert_empty_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_RX_EMPTY] |-> (rx_occ == '0) && !status[ST_RX_FULL]);

  assert_wm_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wm_irq && !rx_pop && !rx_depth_wr |=> rx_wm_irq);

  assert_empty_implies_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_irq |-> tx_half_irq);

  assert_depth_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_depth_wr |=> rx_depth_q == $past(rx_depth_wdata));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status[ST_TX_FULL], status[ST_TX_EMPTY]}) &&
    $onehot0({status[ST_RX_FULL], status[ST_RX_EMPTY]}) &&
    (status[3:0] == 4'h0));
endmodule

bind i2c_fifo_level_unit i2cq_checker #(.DEPTH(DEPTH), .TXW(TXW), .RXW(RXW)) u_chk (.*);

// File: tb/i2c_fifo_level_unit_tb.sv
`timescale 1ns/1ps
module i2c_fifo_level_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_push, tx_pop, rx_push, rx_pop, tx_fifo_rst, rx_depth_wr;
  logic [9:0] tx_wdata, tx_rdata;
  logic [7:0] rx_wdata, rx_rdata, status;
  logic [3:0] rx_depth_wdata, rx_depth_q, tx_occ, rx_occ;
  logic       rx_wm_irq, tx_empty_irq, tx_half_irq;

  int checks = 0;
  int bad    = 0;
  string cur = "R10";
  int txq[$];
  int rxq[$];
  int depth = 0;

  always #2.5 clk = ~clk;

  i2c_fifo_level_unit u_dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s/%s %s actual=%0h expected=%0h", cur, req, what, act, exp);
    end
  endtask

  task automatic compare();
    int ts = txq.size();
    int rs = rxq.size();
    chk("R2", "tx_occ", int'(tx_occ), (ts == 0) ? 0 : ts - 1);
    chk("R2", "rx_occ", int'(rx_occ), (rs == 0) ? 0 : rs - 1);
    chk("R7", "status", int'(status),
        ((ts == 0) << 7) | ((rs == 0) << 6) | ((rs == 16) << 5) | ((ts == 16) << 4));
    chk("R4", "rx_depth_q", int'(rx_depth_q), depth);
    chk("R5", "rx_wm_irq", int'(rx_wm_irq), int'(rs >= depth + 1));
    chk("R8", "tx_empty_irq", int'(tx_empty_irq), int'(ts == 0));
    chk("R8", "tx_half_irq", int'(tx_half_irq), int'(ts <= 8));
    if (ts > 0) chk("R1", "tx_rdata", int'(tx_rdata), txq[0]);
    if (rs > 0) chk("R1", "rx_rdata", int'(rx_rdata), rxq[0]);
  endtask

  // drive at the falling edge, update the model after the rising edge,
  // compare at the next falling edge
  task automatic cyc(bit tp, int tw, bit tpo, bit rp, int rw, bit rpo,
                     bit trst, bit dwr, int dw);
    bit tok, pok;
    tx_push = tp; tx_wdata = 10'(tw); tx_pop = tpo;
    rx_push = rp; rx_wdata = 8'(rw);  rx_pop = rpo;
    tx_fifo_rst = trst; rx_depth_wr = dwr; rx_depth_wdata = 4'(dw);
    @(posedge clk);
    if (trst) txq.delete();
    else begin
      tok = tp && (txq.size() < 16);
      pok = tpo && (txq.size() > 0);
      if (pok) void'(txq.pop_front());
      if (tok) txq.push_back(tw & 10'h3FF);
    end
    tok = rp && (rxq.size() < 16);
    pok = rpo && (rxq.size() > 0);
    if (pok) void'(rxq.pop_front());
    if (tok) rxq.push_back(rw & 8'hFF);
    if (dwr) depth = dw & 15;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; tx_fifo_rst = 0;
    rx_depth_wr = 0; tx_wdata = '0; rx_wdata = '0; rx_depth_wdata = '0;
    rst_n = 1'b0;
    #1;
    // R10: reset state while reset is held
    cur = "R10";
    chk("R10", "status in reset", int'(status), 8'hC0);
    chk("R10", "tx_occ in reset", int'(tx_occ), 0);
    chk("R10", "rx_occ in reset", int'(rx_occ), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare();

    // R1/R3: fill tx past full, then drain past empty
    cur = "R3";
    for (int i = 0; i < 18; i++) cyc(1, (i * 37 + 256) & 1023, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 18; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
    // rx: fill past full
    for (int i = 0; i < 17; i++) cyc(0, 0, 0, 1, i * 13 + 5, 0, 0, 0, 0);

    // R4/R5: watermark sweep on a full receive queue and while draining
    cur = "R4";
    for (int d = 15; d >= 0; d--) cyc(0, 0, 0, 0, 0, 0, 0, 1, d);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 15);
    cur = "R5";
    for (int i = 0; i < 17; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 8'hA5, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, 3);

    // R8: cross the half boundary both ways
    cur = "R8";
    for (int i = 0; i < 10; i++) cyc(1, i + 512, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);

    // R6: hold transmit reset with pushes and pops, then release
    cur = "R6";
    cyc(1, 10'h155, 1, 0, 0, 0, 1, 0, 0);
    cyc(1, 10'h2AA, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 10'h3C3, 0, 0, 0, 0, 0, 0, 0);

    // R9: simultaneous push and pop on both queues
    cur = "R9";
    cyc(1, 10'h011, 0, 1, 8'h22, 0, 0, 0, 0);
    cyc(1, 10'h033, 0, 1, 8'h44, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(1, 700 + i, 1, 1, 100 + i, 1, 0, 0, 0);
    // full queue with push and pop together: push refused
    for (int i = 0; i < 16; i++) cyc(1, 300 + i, 0, 1, 50 + i, 0, 0, 0, 0);
    cyc(1, 10'h3FF, 1, 1, 8'hEE, 1, 0, 0, 0);

    // mixed random traffic
    cur = "R1";
    for (int i = 0; i < 600; i++)
      cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 63) == 0), ($urandom_range(0, 15) == 0),
          int'($urandom_range(0, 15)));

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule